// File: doc/BRIEF.md
# Compare-and-Jump Branch Resolver

This block decides branches for a processor that keeps no condition flag register. A conditional jump carries two register operands. The block subtracts the second operand from the first and derives carry (borrow), zero, negative and overflow from that difference. A 4-bit selector then picks one of sixteen tests on those values. When the test holds, the branch is taken. The target is the address of the branch instruction plus the instruction size plus a sign-extended word offset.

The same block also handles unconditional register jumps. A call jumps to a register value plus an immediate and produces a link value, which is the address of the following instruction, for the caller to write back. A return jumps to the value held in a register and produces no link. All outputs are combinational, so the decision and the address are ready in the same cycle as the operands. Fetch redirection, pipeline flushing and the register write-back all happen outside this block.

Top module: `cjmp_resolver`

## Requirements
- R1: With a branch request, selector 4 is taken when `op_a == op_b`, and selector 5 is taken when they differ.
- R2: Selectors 0, 2, 6 and 7 compare the operands as unsigned numbers. Selector 0 tests `op_a <= op_b`, 2 tests `op_a > op_b`, 6 tests `op_a < op_b` and 7 tests `op_a >= op_b`.
- R3: Carry is the borrow out of `op_a - op_b`. Selector 1 is taken when a borrow occurs, and selector 3 is taken when none occurs.
- R4: Selector 8 is taken when bit 31 of the wrapped 32-bit difference `op_a - op_b` is 1, and selector 9 is taken when that bit is 0.
- R5: Selectors 10, 11, 12 and 13 compare the operands as two's-complement numbers. Selector 10 tests `<`, 11 tests `>=`, 12 tests `<=` and 13 tests `>`.
- R6: Selector 14 is taken when the signed subtraction overflows, and selector 15 is taken when it does not. Overflow means the operand signs differ and the sign of the difference differs from the sign of `op_a`.
- R7: For a branch, `target` equals `pc + 4 + (sign-extended br_off << 2)`, computed modulo 2^32. This holds whether or not the branch is taken.
- R8: With a call request, `taken` is 1, `target` equals `op_a + call_imm` modulo 2^32, `link_valid` is 1 and `link_data` equals `pc + 4`.
- R9: With a return request and no call request, `taken` is 1, `target` equals `op_a` and `link_valid` is 0.
- R10: With no request at all, `taken` and `link_valid` are 0 and `target` equals `pc + 4`.
- R11: When several requests are raised together, call wins over return, and return wins over branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First register operand; also the base for call and return |
| op_b | input | 32 | Second register operand of the compare |
| cond_sel | input | 4 | Condition selector, codes 0 to 15 |
| pc | input | 32 | Address of the jump instruction |
| br_off | input | 16 | Signed word offset of a conditional branch |
| call_imm | input | 32 | Immediate added to `op_a` by a call |
| is_branch | input | 1 | Conditional jump request |
| is_call | input | 1 | Call request |
| is_ret | input | 1 | Return request |
| taken | output | 1 | Control transfers to `target` |
| target | output | 32 | Jump address |
| link_valid | output | 1 | `link_data` must be written back |
| link_data | output | 32 | Return address, `pc + 4` |

## Verification
Random operand pairs are run across all sixteen selectors. These mostly separate the unsigned tests from the signed ones, because random sign bits disagree about half the time. Directed pairs are added where the tests pull apart at their edges: equal operands split the strict tests from the non-strict ones, and 0x80000000 against 1 or 0xFFFFFFFF against 0x7FFFFFFF makes the overflow flag disagree with the negative flag. Zero against one isolates the borrow. Offsets of extreme sign, a program counter near the top of the address space, and requests raised together check the wrap of the address adders and the request priority.

// File: rtl/cjmp_pkg.sv
package cjmp_pkg;

   typedef enum logic [3:0] {
      CJ_ULE = 4'd0,
      CJ_C   = 4'd1,
      CJ_UGT = 4'd2,
      CJ_NC  = 4'd3,
      CJ_EQ  = 4'd4,
      CJ_NE  = 4'd5,
      CJ_ULT = 4'd6,
      CJ_UGE = 4'd7,
      CJ_N   = 4'd8,
      CJ_NN  = 4'd9,
      CJ_SLT = 4'd10,
      CJ_SGE = 4'd11,
      CJ_SLE = 4'd12,
      CJ_SGT = 4'd13,
      CJ_O   = 4'd14,
      CJ_NO  = 4'd15
   } cj_cond_e;

   typedef struct packed {
      logic c;   // borrow out of a - b
      logic z;   // difference is zero
      logic n;   // sign of wrapped difference
      logic v;   // signed overflow
   } cj_flags_t;

endpackage

// File: rtl/cjmp_flags.sv
module cjmp_flags
   import cjmp_pkg::*;
#(
   parameter int  W              = 32,
   parameter bit  ZERO_FROM_DIFF = 1'b1
)(
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output cj_flags_t    flags
);

   localparam int MSB = W - 1;

   logic [W:0] diff;
   logic       zero;

   assign diff = {1'b0, a} - {1'b0, b};

   generate
      if (ZERO_FROM_DIFF) begin : g_zero_diff
         // reuse the subtractor output: reduction on its low bits
         assign zero = ~|diff[MSB:0];
      end else begin : g_zero_cmp
         // parallel comparator: shorter path, more gates
         assign zero = (a == b);
      end
   endgenerate

   assign flags.c = diff[W];
   assign flags.z = zero;
   assign flags.n = diff[MSB];
   assign flags.v = (a[MSB] ^ b[MSB]) & (diff[MSB] ^ a[MSB]);

endmodule

// File: rtl/cjmp_select.sv
module cjmp_select
   import cjmp_pkg::*;
(
   input  cj_flags_t   flags,
   input  logic [3:0]  sel,
   output logic        met
);

   logic lt_s;

   assign lt_s = flags.n ^ flags.v;

   always_comb begin
      unique case (cj_cond_e'(sel))
         CJ_ULE: met = flags.c | flags.z;
         CJ_C:   met = flags.c;
         CJ_UGT: met = ~flags.c & ~flags.z;
         CJ_NC:  met = ~flags.c;
         CJ_EQ:  met = flags.z;
         CJ_NE:  met = ~flags.z;
         CJ_ULT: met = flags.c;
         CJ_UGE: met = ~flags.c;
         CJ_N:   met = flags.n;
         CJ_NN:  met = ~flags.n;
         CJ_SLT: met = lt_s;
         CJ_SGE: met = ~lt_s;
         CJ_SLE: met = lt_s | flags.z;
         CJ_SGT: met = ~lt_s & ~flags.z;
         CJ_O:   met = flags.v;
         CJ_NO:  met = ~flags.v;
         default: met = 1'b0;
      endcase
   end

endmodule

// File: rtl/cjmp_target.sv
module cjmp_target #(
   parameter int W          = 32,
   parameter int OFF_W      = 16,
   parameter int INSN_BYTES = 4
)(
   input  logic [W-1:0]     pc,
   input  logic [OFF_W-1:0] br_off,
   input  logic [W-1:0]     base,
   input  logic [W-1:0]     imm,
   input  logic             is_branch,
   input  logic             is_call,
   input  logic             is_ret,
   input  logic             met,
   output logic             taken,
   output logic [W-1:0]     target,
   output logic             link_valid,
   output logic [W-1:0]     link_data
);

   localparam int       SHIFT = $clog2(INSN_BYTES);
   localparam int       EXT_W = W - OFF_W;
   localparam [W-1:0]   STEP  = W'(INSN_BYTES);

   logic [W-1:0] next_pc;
   logic [W-1:0] off_ext;
   logic [W-1:0] br_tgt;
   logic [W-1:0] reg_tgt;

   assign next_pc = pc + STEP;
   assign off_ext = {{EXT_W{br_off[OFF_W-1]}}, br_off} << SHIFT;
   assign br_tgt  = next_pc + off_ext;
   assign reg_tgt = base + imm;

   always_comb begin
      link_data  = next_pc;
      link_valid = 1'b0;
      taken      = 1'b0;
      target     = next_pc;
      if (is_call) begin
         taken      = 1'b1;
         target     = reg_tgt;
         link_valid = 1'b1;
      end else if (is_ret) begin
         taken  = 1'b1;
         target = base;
      end else if (is_branch) begin
         taken  = met;
         target = br_tgt;
      end
   end

endmodule

// File: rtl/cjmp_resolver.sv
module cjmp_resolver
   import cjmp_pkg::*;
#(
   parameter int W              = 32,
   parameter int OFF_W          = 16,
   parameter int INSN_BYTES     = 4,
   parameter bit ZERO_FROM_DIFF = 1'b1
)(
   input  logic [W-1:0]     op_a,
   input  logic [W-1:0]     op_b,
   input  logic [3:0]       cond_sel,
   input  logic [W-1:0]     pc,
   input  logic [OFF_W-1:0] br_off,
   input  logic [W-1:0]     call_imm,
   input  logic             is_branch,
   input  logic             is_call,
   input  logic             is_ret,
   output logic             taken,
   output logic [W-1:0]     target,
   output logic             link_valid,
   output logic [W-1:0]     link_data
);

   generate
      if (W < 8) begin : g_bad_w
         $error("cjmp_resolver: W must be at least 8");
      end
      if (OFF_W >= W) begin : g_bad_off
         $error("cjmp_resolver: OFF_W must be narrower than W");
      end
      if ((INSN_BYTES & (INSN_BYTES - 1)) != 0) begin : g_bad_step
         $error("cjmp_resolver: INSN_BYTES must be a power of two");
      end
   endgenerate

   cj_flags_t flags;
   logic      met;

   cjmp_flags #(
      .W              (W),
      .ZERO_FROM_DIFF (ZERO_FROM_DIFF)
   ) u_flags (
      .a     (op_a),
      .b     (op_b),
      .flags (flags)
   );

   cjmp_select u_select (
      .flags (flags),
      .sel   (cond_sel),
      .met   (met)
   );

   cjmp_target #(
      .W          (W),
      .OFF_W      (OFF_W),
      .INSN_BYTES (INSN_BYTES)
   ) u_target (
      .pc         (pc),
      .br_off     (br_off),
      .base       (op_a),
      .imm        (call_imm),
      .is_branch  (is_branch),
      .is_call    (is_call),
      .is_ret     (is_ret),
      .met        (met),
      .taken      (taken),
      .target     (target),
      .link_valid (link_valid),
      .link_data  (link_data)
   );

endmodule

// File: rtl/cjmp_resolver_chk.sv
module cjmp_resolver_chk #(
   parameter int W          = 32,
   parameter int INSN_BYTES = 4
)(
   input logic [W-1:0] op_a,
   input logic [W-1:0] op_b,
   input logic [3:0]   cond_sel,
   input logic [W-1:0] pc,
   input logic         is_branch,
   input logic         is_call,
   input logic         is_ret,
   input logic         taken,
   input logic [W-1:0] target,
   input logic         link_valid,
   input logic [W-1:0] link_data
);

   logic only_br;
   assign only_br = is_branch & ~is_call & ~is_ret;

   always_comb begin
      if (only_br && cond_sel == 4'd4)
         p_eq_r1: assert (taken == (op_a == op_b));
      if (only_br && cond_sel == 4'd6)
         p_ult_r2: assert (taken == (op_a < op_b));
      if (only_br && cond_sel == 4'd1)
         p_carry_r3: assert (taken == (op_a < op_b));
      if (only_br && cond_sel == 4'd10)
         p_slt_r5: assert (taken == ($signed(op_a) < $signed(op_b)));
      if (is_call)
         p_call_link_r8: assert (taken && link_valid && link_data == pc + W'(INSN_BYTES));
      if (is_ret && !is_call)
         p_ret_r9: assert (taken && !link_valid && target == op_a);
      if (!is_branch && !is_call && !is_ret)
         p_idle_r10: assert (!taken && !link_valid);
   end

endmodule

bind cjmp_resolver cjmp_resolver_chk #(
   .W          (W),
   .INSN_BYTES (INSN_BYTES)
) u_chk (
   .op_a       (op_a),
   .op_b       (op_b),
   .cond_sel   (cond_sel),
   .pc         (pc),
   .is_branch  (is_branch),
   .is_call    (is_call),
   .is_ret     (is_ret),
   .taken      (taken),
   .target     (target),
   .link_valid (link_valid),
   .link_data  (link_data)
);

// File: tb/cjmp_resolver_tb.sv
module cjmp_resolver_tb;

   logic        clk = 1'b0;
   logic [31:0] op_a = '0, op_b = '0, pc = '0, call_imm = '0;
   logic [3:0]  cond_sel = '0;
   logic [15:0] br_off = '0;
   logic        is_branch = 1'b0, is_call = 1'b0, is_ret = 1'b0;
   logic        taken, link_valid;
   logic [31:0] target, link_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;   // 250 MHz

   cjmp_resolver u_dut (
      .op_a(op_a), .op_b(op_b), .cond_sel(cond_sel), .pc(pc),
      .br_off(br_off), .call_imm(call_imm), .is_branch(is_branch),
      .is_call(is_call), .is_ret(is_ret), .taken(taken),
      .target(target), .link_valid(link_valid), .link_data(link_data)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // reference condition, built from widened signed arithmetic
   function automatic logic ref_met(input logic [31:0] a, input logic [31:0] b,
                                    input logic [3:0] s);
      longint sa, sb, sd;
      logic   ult, eq, slt, neg, ovf;
      sa  = longint'($signed(a));
      sb  = longint'($signed(b));
      sd  = sa - sb;
      ult = (a < b);
      eq  = (a == b);
      slt = (sa < sb);
      neg = sd[31];
      ovf = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
      case (s)
         4'd0:  return ult | eq;
         4'd1:  return ult;
         4'd2:  return !ult && !eq;
         4'd3:  return !ult;
         4'd4:  return eq;
         4'd5:  return !eq;
         4'd6:  return ult;
         4'd7:  return !ult;
         4'd8:  return neg;
         4'd9:  return !neg;
         4'd10: return slt;
         4'd11: return !slt;
         4'd12: return slt | eq;
         4'd13: return !slt && !eq;
         4'd14: return ovf;
         default: return !ovf;
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] s);
      case (s)
         4'd4, 4'd5:                return "R1";
         4'd0, 4'd2, 4'd6, 4'd7:    return "R2";
         4'd1, 4'd3:                return "R3";
         4'd8, 4'd9:                return "R4";
         4'd14, 4'd15:              return "R6";
         default:                   return "R5";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // apply one request, then compare every output
   task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [3:0] s,
                      input logic [31:0] p, input logic [15:0] off, input logic [31:0] im,
                      input logic br, input logic cl, input logic rt);
      logic [31:0] e_tgt;
      logic        e_tk, e_lv;
      string       t;
      @(negedge clk);
      op_a = a; op_b = b; cond_sel = s; pc = p; br_off = off; call_imm = im;
      is_branch = br; is_call = cl; is_ret = rt;
      #1;
      if (cl) begin
         e_tk = 1'b1; e_tgt = a + im; e_lv = 1'b1;
         t = (br || rt) ? "R11" : "R8";
      end else if (rt) begin
         e_tk = 1'b1; e_tgt = a; e_lv = 1'b0;
         t = br ? "R11" : "R9";
      end else if (br) begin
         e_tk = ref_met(a, b, s);
         e_tgt = p + 32'd4 + ({{16{off[15]}}, off} << 2);
         e_lv = 1'b0;
         t = tag_of(s);
      end else begin
         e_tk = 1'b0; e_tgt = p + 32'd4; e_lv = 1'b0;
         t = "R10";
      end
      chk(t, {31'd0, taken}, {31'd0, e_tk});
      chk(br && !cl && !rt ? "R7" : t, target, e_tgt);
      chk(t, {31'd0, link_valid}, {31'd0, e_lv});
      if (cl) chk("R8", link_data, p + 32'd4);
   endtask

   initial begin
      logic [31:0] dir_a [8];
      logic [31:0] dir_b [8];
      void'($urandom(32'd1234));
      dir_a = '{32'h0, 32'h0, 32'h1, 32'h8000_0000, 32'h0000_0001,
                32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h1234_5678};
      dir_b = '{32'h0, 32'h1, 32'h0, 32'h0000_0001, 32'h8000_0000,
                32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h1234_5678};

      // reset-state style idle check (R10)
      run(32'h0, 32'h0, 4'd0, 32'h0, 16'h0, 32'h0, 1'b0, 1'b0, 1'b0);

      // directed corner pairs across every selector
      for (int i = 0; i < 8; i++)
         for (int s = 0; s < 16; s++)
            run(dir_a[i], dir_b[i], 4'(s), 32'h0000_1000, 16'h0010, 32'h0,
                1'b1, 1'b0, 1'b0);

      // R7 offset extremes and address wrap
      run(32'h5, 32'h5, 4'd4, 32'hFFFF_FFFC, 16'h7FFF, 32'h0, 1'b1, 1'b0, 1'b0);
      run(32'h5, 32'h6, 4'd4, 32'h0000_0008, 16'h8000, 32'h0, 1'b1, 1'b0, 1'b0);
      // R8 call wrap, R9 return, R11 priority
      run(32'hFFFF_FFF0, 32'h0, 4'd0, 32'hFFFF_FFFC, 16'h0, 32'h20, 1'b0, 1'b1, 1'b0);
      run(32'h0000_4000, 32'h0, 4'd0, 32'h100, 16'h0, 32'h0, 1'b0, 1'b0, 1'b1);
      run(32'h0000_4000, 32'h0, 4'd4, 32'h100, 16'h3, 32'h8, 1'b1, 1'b1, 1'b1);
      run(32'h0000_4000, 32'h0, 4'd4, 32'h100, 16'h3, 32'h8, 1'b1, 1'b0, 1'b1);

      // constrained random mix
      for (int n = 0; n < 1500; n++) begin
         int unsigned m = $urandom_range(0, 9);
         logic [31:0] a = $urandom();
         logic [31:0] b = ($urandom_range(0, 7) == 0) ? a : 32'($urandom());
         run(a, b, 4'($urandom_range(0, 15)), {$urandom()} & 32'hFFFF_FFFC,
             16'($urandom()), $urandom(),
             (m < 6) || (m == 9), (m == 6) || (m == 9), (m == 7) || (m == 9));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule